// File: doc/BRIEF.md
# Unaligned Byte Transfer Sequencer

This block carries a byte-granular read or write request, given as a start address and a byte length, across a word port that accepts only aligned 32-bit and 64-bit accesses. The client issues a request on a one-cycle valid/ready handshake. On a write, bytes are pulled one per cycle from a byte stream. On a read, bytes are pushed out one per cycle in ascending address order. A single completion pulse reports the outcome and the byte count.

Each word access carries an address, a width flag and write data, and is held until the port acknowledges it. The acknowledge returns read data and an error flag. Partial words at the head and tail of a write are completed by reading the containing 32-bit word, merging the new bytes into it and writing it back. The port cannot perform a 64-bit access that straddles a 1 KiB boundary. The sequencer therefore slips in one 32-bit access whenever the 4-aligned remainder is not 8-aligned and the transfer's end lies in a different 1 KiB block.

The control is one state machine:
- `S_IDLE` waits for a request.
- `S_PLAN` picks the next segment.
- `S_FETCH` reads the old word for a merge.
- `S_GATHER` collects write bytes.
- `S_STORE` writes a word.
- `S_LOAD` reads a word.
- `S_EMIT` streams read bytes.
- `S_DONE` pulses completion.

Its transitions are:
- IDLE to DONE on a zero-length request, and IDLE to PLAN otherwise.
- PLAN to FETCH for a partial write segment, PLAN to GATHER for a full write segment, and PLAN to LOAD for a read.
- FETCH to GATHER on a clean acknowledge.
- GATHER to STORE after the segment's last byte.
- STORE to PLAN, or STORE to DONE on the final segment.
- LOAD to EMIT on a clean acknowledge.
- EMIT to PLAN, or EMIT to DONE on the final segment.
- FETCH, STORE and LOAD to DONE on an erroneous acknowledge.
- DONE to IDLE.

Top module: `xfer_splitter`

## Requirements
- R1: After reset the block is idle. `req_ready` is high, and `wp_req`, `wr_ready`, `rd_valid` and `done` are low.
- R2: Every word access uses an address with bits [1:0] zero. When the start address is not 4-aligned, the first segment covers the containing aligned word and moves min(4 − misalignment, length) bytes. On a write this segment is a 32-bit read followed by a 32-bit write to the same address.
- R3: After the head, if the address is not 8-aligned and (address XOR (address + remaining)) has any bit at position 10 or above set, exactly one 32-bit access is made before any 64-bit access.
- R4: The remaining length rounded down to a multiple of 8 moves as 64-bit accesses (`wp_wide`=1), and no 64-bit access spans a 1 KiB boundary.
- R5: If 4 to 7 bytes then remain, one full 32-bit access moves 4 of them.
- R6: A final 1 to 3 bytes use a 32-bit read. On a write, the new bytes are merged starting at byte offset 0 and the word is written back, so bytes outside the requested range keep their old values.
- R7: Byte order is little-endian: byte k of a word occupies bits [8k+7:8k]. 32-bit accesses use bits [31:0]. Read bytes leave on `rd_data` in ascending address order, and write bytes are consumed in the same order.
- R8: An acknowledge with `wp_err` high ends the transfer. No further word access is issued, and the next cycle shows `done` with `done_err` high and `done_count` zero.
- R9: A successful transfer ends with one `done` pulse, `done_err` low, and `done_count` equal to the requested length.
- R10: A zero-length request gives `done` in the cycle after acceptance and issues no word access.
- R11: While `wp_req` is high and unacknowledged, address, direction, width and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Byte length |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte consumed this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte present |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Completion pulse |
| done_err | output | 1 | Transfer aborted by port error |
| done_count | output | LW | Bytes reported moved |
| wp_req | output | 1 | Word access request, held until acknowledge |
| wp_write | output | 1 | Word access is a write |
| wp_wide | output | 1 | 1 = 64-bit access, 0 = 32-bit access |
| wp_addr | output | AW | Word access byte address |
| wp_wdata | output | 64 | Word write data |
| wp_ack | input | 1 | Word access complete |
| wp_rdata | input | 64 | Word read data |
| wp_err | input | 1 | Word access failed |

## Verification
Completion and abort can coincide: an error can arrive on the acknowledge of the final access of a transfer, in the same cycle the sequencer would otherwise declare success. The bench provokes this by repeating one unaligned transfer that crosses a 1 KiB boundary, injecting the error at every access index from the first to the last, for both reads and writes. Each run is judged by `done_err` being high, `done_count` being zero, and the number of accesses seen equalling the error index plus one. A second overlap, a write segment whose merge read and byte gathering share one word buffer, is judged by comparing the memory model byte for byte around every written range.

// File: rtl/xs_pkg.sv
package xs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PLAN,
        S_FETCH,
        S_GATHER,
        S_STORE,
        S_LOAD,
        S_EMIT,
        S_DONE
    } xs_state_e;

    localparam int NARROW_BYTES = 4;
    localparam int WIDE_BYTES   = 8;

endpackage

// File: rtl/xs_planner.sv
// Chooses the next word segment from the current byte address and remaining length.
module xs_planner #(
    parameter int AW     = 12,
    parameter int LW     = 12,
    parameter int BLK_LG = 10
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [LW-1:0] remain,
    output logic [AW-1:0] word_addr,
    output logic [2:0]    first_lane,
    output logic [3:0]    nbytes,
    output logic          wide,
    output logic          partial
);
    localparam int SW = ((AW > LW) ? AW : LW) + 1;

    logic [SW-1:0] a_ext;
    logic [SW-1:0] end_ext;
    logic          crosses_block;
    logic [3:0]    head_room;

    assign a_ext         = SW'(cur_addr);
    assign end_ext       = a_ext + SW'(remain);
    assign crosses_block = |((a_ext ^ end_ext) >> BLK_LG);
    assign head_room     = 4'd4 - {2'b00, cur_addr[1:0]};

    always_comb begin
        word_addr  = {cur_addr[AW-1:2], 2'b00};
        first_lane = 3'd0;
        wide       = 1'b0;
        nbytes     = 4'd4;
        if (cur_addr[1:0] != 2'b00) begin
            first_lane = {1'b0, cur_addr[1:0]};
            nbytes     = (remain < LW'(head_room)) ? remain[3:0] : head_room;
        end else if (cur_addr[2] && crosses_block) begin
            nbytes = 4'd4;
        end else if (remain >= LW'(xs_pkg::WIDE_BYTES)) begin
            wide   = 1'b1;
            nbytes = 4'd8;
        end else if (remain >= LW'(xs_pkg::NARROW_BYTES)) begin
            nbytes = 4'd4;
        end else begin
            nbytes = remain[3:0];
        end
    end

    assign partial = !wide && (nbytes < 4'd4);

endmodule

// File: rtl/xs_lanes.sv
// Byte-lane select and merge over the 64-bit word buffer (little-endian lanes).
module xs_lanes #(
    parameter int LANES = 8
) (
    input  logic [8*LANES-1:0]       word,
    input  logic [$clog2(LANES)-1:0] lane,
    input  logic [7:0]               new_byte,
    output logic [7:0]               pick,
    output logic [8*LANES-1:0]       merged
);
    localparam int LSW = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[8*g +: 8] = (lane == LSW'(g)) ? new_byte : word[8*g +: 8];
    end

    always_comb begin
        pick = word[8*lane +: 8];
    end

endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter #(
    parameter int AW     = 12,
    parameter int LW     = 12,
    parameter int BLK_LG = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [7:0]    wr_data,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          done,
    output logic          done_err,
    output logic [LW-1:0] done_count,
    output logic          wp_req,
    output logic          wp_write,
    output logic          wp_wide,
    output logic [AW-1:0] wp_addr,
    output logic [63:0]   wp_wdata,
    input  logic          wp_ack,
    input  logic [63:0]   wp_rdata,
    input  logic          wp_err
);
    import xs_pkg::*;

    localparam int LANES = WIDE_BYTES;
    localparam int LSW   = $clog2(LANES);

    xs_state_e state_q, state_d;

    logic [AW-1:0]      cur_addr;
    logic [LW-1:0]      remain;
    logic [LW-1:0]      total;
    logic               is_wr;
    logic               fail;
    logic [AW-1:0]      seg_waddr;
    logic [LSW-1:0]     seg_lane0;
    logic [3:0]         seg_n;
    logic               seg_wide;
    logic [LSW-1:0]     idx;
    logic [8*LANES-1:0] wbuf;

    logic [AW-1:0]      pl_waddr;
    logic [2:0]         pl_lane0;
    logic [3:0]         pl_n;
    logic               pl_wide;
    logic               pl_partial;
    logic [LSW-1:0]     lane;
    logic [7:0]         lane_pick;
    logic [8*LANES-1:0] lane_merged;
    logic               last_byte;
    logic               final_seg;
    logic [63:0]        rdata_fit;

    xs_planner #(.AW(AW), .LW(LW), .BLK_LG(BLK_LG)) u_planner (
        .cur_addr   (cur_addr),
        .remain     (remain),
        .word_addr  (pl_waddr),
        .first_lane (pl_lane0),
        .nbytes     (pl_n),
        .wide       (pl_wide),
        .partial    (pl_partial)
    );

    assign lane = seg_lane0 + idx;

    xs_lanes #(.LANES(LANES)) u_lanes (
        .word     (wbuf),
        .lane     (lane),
        .new_byte (wr_data),
        .pick     (lane_pick),
        .merged   (lane_merged)
    );

    assign last_byte = ({1'b0, idx} == (seg_n - 4'd1));
    assign final_seg = (remain == LW'(seg_n));
    assign rdata_fit = seg_wide ? wp_rdata : {32'h0, wp_rdata[31:0]};

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = (req_len == '0) ? S_DONE : S_PLAN;
            S_PLAN:   state_d = is_wr ? (pl_partial ? S_FETCH : S_GATHER) : S_LOAD;
            S_FETCH:  if (wp_ack) state_d = wp_err ? S_DONE : S_GATHER;
            S_GATHER: if (wr_valid && last_byte) state_d = S_STORE;
            S_STORE:  if (wp_ack) state_d = (wp_err || final_seg) ? S_DONE : S_PLAN;
            S_LOAD:   if (wp_ack) state_d = wp_err ? S_DONE : S_EMIT;
            S_EMIT:   if (last_byte) state_d = final_seg ? S_DONE : S_PLAN;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cur_addr  <= '0;
            remain    <= '0;
            total     <= '0;
            is_wr     <= 1'b0;
            fail      <= 1'b0;
            seg_waddr <= '0;
            seg_lane0 <= '0;
            seg_n     <= '0;
            seg_wide  <= 1'b0;
            idx       <= '0;
            wbuf      <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        cur_addr <= req_addr;
                        remain   <= req_len;
                        total    <= req_len;
                        is_wr    <= req_write;
                        fail     <= 1'b0;
                    end
                end
                S_PLAN: begin
                    seg_waddr <= pl_waddr;
                    seg_lane0 <= LSW'(pl_lane0);
                    seg_n     <= pl_n;
                    seg_wide  <= pl_wide;
                    idx       <= '0;
                    wbuf      <= '0;
                end
                S_FETCH, S_LOAD: begin
                    if (wp_ack) begin
                        if (wp_err) fail <= 1'b1;
                        else        wbuf <= rdata_fit;
                    end
                end
                S_GATHER: begin
                    if (wr_valid) begin
                        wbuf <= lane_merged;
                        idx  <= idx + 1'b1;
                    end
                end
                S_STORE: begin
                    if (wp_ack) begin
                        if (wp_err) begin
                            fail <= 1'b1;
                        end else begin
                            cur_addr <= cur_addr + AW'(seg_n);
                            remain   <= remain - LW'(seg_n);
                        end
                    end
                end
                S_EMIT: begin
                    idx <= idx + 1'b1;
                    if (last_byte) begin
                        cur_addr <= cur_addr + AW'(seg_n);
                        remain   <= remain - LW'(seg_n);
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        wr_ready   = 1'b0;
        rd_valid   = 1'b0;
        done       = 1'b0;
        wp_req     = 1'b0;
        wp_write   = 1'b0;
        unique case (state_q)
            S_IDLE:   req_ready = 1'b1;
            S_PLAN:   ;
            S_FETCH:  wp_req = 1'b1;
            S_GATHER: wr_ready = 1'b1;
            S_STORE:  begin wp_req = 1'b1; wp_write = 1'b1; end
            S_LOAD:   wp_req = 1'b1;
            S_EMIT:   rd_valid = 1'b1;
            S_DONE:   done = 1'b1;
            default:  ;
        endcase
        rd_data    = lane_pick;
        done_err   = done && fail;
        done_count = fail ? '0 : total;
        wp_wide    = seg_wide;
        wp_addr    = seg_waddr;
        wp_wdata   = wbuf;
    end

endmodule

// File: rtl/xs_checker.sv
module xs_checker #(
    parameter int AW     = 12,
    parameter int LW     = 12,
    parameter int BLK_LG = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [LW-1:0] req_len,
    input logic          wr_ready,
    input logic          rd_valid,
    input logic          done,
    input logic          done_err,
    input logic [LW-1:0] done_count,
    input logic          wp_req,
    input logic          wp_write,
    input logic          wp_wide,
    input logic [AW-1:0] wp_addr,
    input logic [63:0]   wp_wdata,
    input logic          wp_ack,
    input logic          wp_err
);
    logic [LW-1:0] len_q;
    logic [AW:0]   wide_first;
    logic [AW:0]   wide_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      len_q <= '0;
        else if (req_valid && req_ready) len_q <= req_len;
    end

    assign wide_first = {1'b0, wp_addr};
    assign wide_last  = {1'b0, wp_addr} + (AW+1)'(7);

    a_r1_one_activity: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, wr_ready, rd_valid, done, wp_req}));

    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wp_req |-> (wp_addr[1:0] == 2'b00));

    a_r4_wide_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_req && wp_wide) |-> ((wide_first >> BLK_LG) == (wide_last >> BLK_LG)));

    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_req && wp_ack && wp_err) |=> (done && done_err && !wp_req));

    a_r9_count: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_err) |-> (done_count == len_q));

    a_r10_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len == '0) |=> (done && !done_err && !wp_req));

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_req && !wp_ack) |=> (wp_req && $stable(wp_addr) && $stable(wp_write)
                                 && $stable(wp_wide) && $stable(wp_wdata)));

endmodule

bind xfer_splitter xs_checker #(.AW(AW), .LW(LW), .BLK_LG(BLK_LG)) u_xs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_len    (req_len),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .done       (done),
    .done_err   (done_err),
    .done_count (done_count),
    .wp_req     (wp_req),
    .wp_write   (wp_write),
    .wp_wide    (wp_wide),
    .wp_addr    (wp_addr),
    .wp_wdata   (wp_wdata),
    .wp_ack     (wp_ack),
    .wp_err     (wp_err)
);

// File: tb/xfer_splitter_bench.sv
module xfer_splitter_bench;
    localparam int AW  = 12;
    localparam int LW  = 12;
    localparam int MEM = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [7:0]    wr_data = '0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic          done;
    logic          done_err;
    logic [LW-1:0] done_count;
    logic          wp_req;
    logic          wp_write;
    logic          wp_wide;
    logic [AW-1:0] wp_addr;
    logic [63:0]   wp_wdata;
    logic          wp_ack = 1'b0;
    logic [63:0]   wp_rdata = '0;
    logic          wp_err = 1'b0;

    always #5 clk = ~clk;

    xfer_splitter #(.AW(AW), .LW(LW), .BLK_LG(10)) u_xfer_splitter (.*);

    logic [7:0] mem  [MEM];
    logic [7:0] refm [MEM];
    logic [7:0] src  [256];
    logic [7:0] rdb  [256];

    int vectors = 0;
    int fails = 0;
    int rd_cnt, acc_cnt, err_at, ptr;
    bit took, feeding, pending, done_seen, got_err;
    int got_count;
    int wide_bad;
    logic [AW-1:0] p_addr;
    logic p_write;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected number of word accesses, from the requirements
    function automatic int exp_acc(input int a, input int n, input bit w);
        int c = 0;
        int s;
        if (n == 0) return 0;
        if ((a % 4) != 0) begin
            s = 4 - (a % 4);
            if (s > n) s = n;
            c += w ? 2 : 1;
            a += s; n -= s;
        end
        if (n > 0 && (a % 8) != 0 && (((a ^ (a + n)) >> 10) != 0)) begin
            c++; a += 4; n -= 4;
        end
        c += n / 8;
        n = n % 8;
        if (n >= 4) begin c++; n -= 4; end
        if (n > 0) c += w ? 2 : 1;
        return c;
    endfunction

    // port model, stream feeder and monitors, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (wp_ack) begin
                wp_ack = 1'b0;
                wp_err = 1'b0;
            end else if (pending) begin
                chk(wp_req && wp_addr == p_addr && wp_write == p_write,
                    "R11 request hold", longint'(wp_addr), longint'(p_addr));
                if (wp_wide && ((int'(wp_addr) >> 10) != ((int'(wp_addr) + 7) >> 10)))
                    wide_bad++;
                if (acc_cnt == err_at) begin
                    wp_err = 1'b1;
                end else if (wp_write) begin
                    for (int b = 0; b < (wp_wide ? 8 : 4); b++)
                        mem[(int'(wp_addr) + b) % MEM] = wp_wdata[8*b +: 8];
                end else begin
                    wp_rdata = '0;
                    for (int b = 0; b < (wp_wide ? 8 : 4); b++)
                        wp_rdata[8*b +: 8] = mem[(int'(wp_addr) + b) % MEM];
                end
                acc_cnt++;
                wp_ack = 1'b1;
                pending = 1'b0;
            end else if (wp_req) begin
                pending = 1'b1;
                p_addr = wp_addr;
                p_write = wp_write;
            end
            if (took) ptr++;
            wr_data = src[ptr % 256];
            wr_valid = feeding;
            took = feeding && wr_ready;
            if (rd_valid) begin
                rdb[rd_cnt % 256] = rd_data;
                rd_cnt++;
            end
            if (done) begin
                done_seen = 1'b1;
                got_err = done_err;
                got_count = int'(done_count);
            end
        end
    end

    task automatic run(input int a, input int n, input bit w, input int ea);
        int exp_n;
        int lo, hi;
        bit ok;
        @(negedge clk); #1;
        rd_cnt = 0; acc_cnt = 0; err_at = ea; ptr = 0; took = 1'b0;
        done_seen = 1'b0; wide_bad = 0;
        for (int i = 0; i < 256; i++) src[i] = 8'((a * 7 + i * 13 + n * 3 + (w ? 91 : 0)) & 255);
        feeding = w;
        req_valid = 1'b1; req_addr = AW'(a); req_len = LW'(n); req_write = w;
        @(negedge clk); #1;
        req_valid = 1'b0;
        for (int t = 0; t < 2000 && !done_seen; t++) @(negedge clk);
        #1;
        feeding = 1'b0;
        if (!done_seen) begin
            chk(1'b0, "R9 completion timeout", 0, 1);
            return;
        end
        exp_n = exp_acc(a, n, w);
        chk(wide_bad == 0, "R4 wide access inside 1KiB block", wide_bad, 0);
        if (ea >= 0) begin
            chk(got_err, "R8 error reported", got_err, 1);
            chk(got_count == 0, "R8 count zero on abort", got_count, 0);
            chk(acc_cnt == ea + 1, "R8 no access after error", acc_cnt, ea + 1);
            for (int i = 0; i < MEM; i++) refm[i] = mem[i];
            return;
        end
        chk(!got_err, "R9 no error", got_err, 0);
        chk(got_count == n, "R9 count equals length", got_count, n);
        if (n == 0) chk(acc_cnt == 0, "R10 zero length no access", acc_cnt, 0);
        else chk(acc_cnt == exp_n, "R2 R3 R5 R6 access count", acc_cnt, exp_n);
        if (w) begin
            for (int i = 0; i < n; i++) refm[(a + i) % MEM] = src[i];
            lo = a - 8; hi = a + n + 8;
            ok = 1'b1;
            for (int i = lo; i < hi; i++)
                if (i >= 0 && i < MEM && mem[i] != refm[i]) ok = 1'b0;
            chk(ok, "R6 R7 memory after write", ok, 1);
            chk(ptr == n, "R7 write bytes consumed", ptr, n);
        end else begin
            chk(rd_cnt == n, "R7 read byte count", rd_cnt, n);
            ok = 1'b1;
            for (int i = 0; i < n; i++)
                if (rdb[i] != mem[(a + i) % MEM]) ok = 1'b0;
            chk(ok, "R7 read bytes ascending little-endian", ok, 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        pending = 1'b0; feeding = 1'b0; took = 1'b0; ptr = 0;
        rd_cnt = 0; acc_cnt = 0; err_at = -1; done_seen = 1'b0; wide_bad = 0;
        for (int i = 0; i < MEM; i++) begin
            mem[i] = 8'((i * 5 + 3) ^ (i >> 8));
            refm[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 idle ready", req_ready, 1);
        chk(!wp_req && !wr_ready && !rd_valid && !done, "R1 quiet outputs",
            {wp_req, wr_ready, rd_valid, done}, 0);

        for (int a = 'h3E8; a < 'h400; a++)
            for (int n = 0; n <= 20; n++) begin
                run(a, n, 1'b1, -1);
                run(a, n, 1'b0, -1);
            end

        run('h3F4, 100, 1'b1, -1);
        run('h3F4, 100, 1'b0, -1);
        run('h003, 37, 1'b1, -1);
        run('h7FD, 60, 1'b0, -1);
        run('hFF4, 12, 1'b1, -1);
        run('hFF4, 12, 1'b0, -1);

        for (int k = 0; k < exp_acc('h3FD, 13, 1'b1); k++) run('h3FD, 13, 1'b1, k);
        for (int k = 0; k < exp_acc('h3FD, 13, 1'b0); k++) run('h3FD, 13, 1'b0, k);
        run('h3FD, 13, 1'b0, -1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule